// File: doc/BRIEF.md
# GF(2^89) Digit-Serial Field Multiplier

This block multiplies two elements of the binary field GF(2^89). Elements are held in polynomial basis: bit i of a word is the coefficient of u^i. The field is defined by the trinomial u^89 + u^38 + 1. The second operand is consumed four bits per cycle, most significant digit first. The accumulator is reduced in the same step as each shift, so the working value never grows wider than the field.

A caller presents both operands and pulses `start` while the unit is idle. `busy` stays high while the digits are processed. `done` then pulses for one cycle, and the product stays on `product` until the next accepted start. A clock-enable input gates every register in the block. Dropping it freezes all state, including a multiplication already in progress. While the unit is idle and `start` is low, no register changes.

Top module: `gf89_digit_mul`

## Requirements
- R1: After reset, `product` is zero and both `done` and `busy` are low.
- R2: The result equals a·b reduced modulo u^89 + u^38 + 1, with bit i of each 89-bit word being the coefficient of u^i.
- R3: An enabled edge with `start` high and `busy` low loads the operands and raises `busy`. The multiplier operand is zero-padded to 92 bits and consumed 4 bits per enabled cycle, top digit first. `done` is therefore high exactly 23 enabled edges after the loading edge.
- R4: `done` is high for a single enabled cycle, and `busy` is low whenever `done` is high.
- R5: `product` keeps its value from the `done` edge until the next accepted start, whatever the operand inputs do.
- R6: A `start` pulse while `busy` is high has no effect: neither the result nor the completion time changes.
- R7: While `clk_en` is low, `product`, `done`, `busy` and all internal state keep their values. When `clk_en` returns high, the operation resumes and completes with the correct result, late by the number of gated cycles.
- R8: While idle with `start` low, no output changes.
- R9: The operand cases zero, one and all-ones give the correct result on either side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock-enable; low freezes all registers |
| start | input | 1 | Request a multiplication (accepted only when idle) |
| op_a | input | 89 | Multiplicand, polynomial basis |
| op_b | input | 89 | Multiplier, consumed 4 bits per cycle |
| product | output | 89 | Result, held until next accepted start |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while digits are being processed |

## Verification
A fault in the shift-and-fold logic or in the partial-product terms changes `product` at the `done` edge. Walking single-bit operands locate the fault to particular bit positions, because each one exercises a single coefficient path through the fold at 0..3 and 38..41. An off-by-one in the step counter or the operand padding shows up at the port as `done` arriving a cycle early or late, which also truncates or shifts the product. An enable path that misses a register shows up as a changed `product` or `busy` during a gated window, or as a wrong result after resuming.

// File: rtl/gf89_digit_mul.sv
module gf89_digit_mul #(
  parameter int W   = 89,
  parameter int D   = 4,
  parameter int TAP = 38
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] product,
  output logic         done,
  output logic         busy
);
  localparam int STEPS = (W + D - 1) / D;
  localparam int PADW  = STEPS * D;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [W-1:0] RED = (W'(1) << TAP) | W'(1);

  function automatic logic [W-1:0] xtime(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ (v[W-1] ? RED : '0);
  endfunction

  logic [W-1:0]    a_q, acc_q;
  logic [PADW-1:0] b_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q;

  logic [D-1:0]    dig;
  logic [D-1:0]    top;
  logic [W-1:0]    shifted;
  logic [W-1:0]    a_pow [D];
  logic [W-1:0]    pp;
  logic [W-1:0]    acc_nxt;

  assign dig     = b_q[PADW-1 -: D];
  assign top     = acc_q[W-1 -: D];
  assign shifted = {acc_q[W-D-1:0], {D{1'b0}}} ^ W'(top) ^ (W'(top) << TAP);

  always_comb begin
    a_pow[0] = a_q;
    for (int j = 1; j < D; j++) a_pow[j] = xtime(a_pow[j-1]);
    pp = '0;
    for (int j = 0; j < D; j++) if (dig[j]) pp = pp ^ a_pow[j];
  end

  assign acc_nxt = shifted ^ pp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      acc_q  <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (clk_en) begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          a_q    <= op_a;
          b_q    <= PADW'(op_b);
          acc_q  <= '0;
          cnt_q  <= CW'(STEPS);
          busy_q <= 1'b1;
        end
      end else begin
        acc_q <= acc_nxt;
        b_q   <= b_q << D;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign product = acc_q;
  assign done    = done_q;
  assign busy    = busy_q;
endmodule

// File: rtl/gf89_mul_checks.sv
module gf89_mul_checks #(
  parameter int W     = 89,
  parameter int STEPS = 23
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clk_en,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] product
);
  logic [15:0] steps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) steps_q <= '0;
    else if (clk_en) begin
      if (start && !busy) steps_q <= '0;
      else if (busy)      steps_q <= steps_q + 16'd1;
    end
  end

  assert_gate_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(product) && $stable(busy) && $stable(done)));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clk_en) |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && start && !busy) |=> busy);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (steps_q == 16'(STEPS)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(clk_en && start)) |=> $stable(product));
endmodule

bind gf89_digit_mul gf89_mul_checks #(.W(W), .STEPS(STEPS)) u_checks (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/tb_gf89_digit_mul.sv
module tb_gf89_digit_mul;
  localparam int W = 89;
  localparam int STEPS = 23;
  localparam logic [W-1:0] RED = (W'(1) << 38) | W'(1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] product;
  logic done, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gf89_digit_mul dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
    .op_a(op_a), .op_b(op_b), .product(product), .done(done), .busy(busy)
  );

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = {r[W-2:0], 1'b0} ^ (r[W-1] ? RED : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input int gate_at, input int gate_len, input int mid_start,
                         input string req);
    logic [W-1:0] exp = ref_mul(a, b);
    logic [W-1:0] snap;
    bit early = 0;
    bit frozen_ok = 1;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1; clk_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= STEPS; k++) begin
      start = 1'b0;
      if (k == mid_start) begin
        start = 1'b1; op_a = ~a; op_b = a ^ b;
      end
      if (k == gate_at) begin
        clk_en = 1'b0;
        snap = product;
        for (int g = 0; g < gate_len; g++) begin
          @(negedge clk);
          if (product !== snap || busy !== 1'b1 || done !== 1'b0) frozen_ok = 0;
        end
        clk_en = 1'b1;
      end
      if (done !== 1'b0 || busy !== 1'b1) early = 1;
      @(negedge clk);
    end
    start = 1'b0;
    if (gate_len > 0) check(frozen_ok, "R7 frozen during gate", product, snap);
    check(!early, "R3 busy/no early done", W'(done), W'(0));
    check(done === 1'b1 && busy === 1'b0, "R3/R4 done at step 23", W'({done, busy}), W'(2));
    check(product === exp, req, product, exp);
    op_a = ~a; op_b = ~b;
    @(negedge clk);
    check(done === 1'b0, "R4 single-cycle done", W'(done), W'(0));
    check(product === exp, "R5 hold after done", product, exp);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ones = '1;
    logic [W-1:0] one  = W'(1);
    logic [W-1:0] ra, rb, held;
    repeat (3) @(negedge clk);
    check(product === '0 && done === 1'b0 && busy === 1'b0, "R1 reset state",
          product, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_mul('0, ones, 0, 0, 0, "R9 zero times all-ones");
    run_mul(ones, '0, 0, 0, 0, "R9 all-ones times zero");
    run_mul(one, ones, 0, 0, 0, "R9 one times all-ones");
    run_mul(ones, one, 0, 0, 0, "R9 all-ones times one");
    run_mul(ones, ones, 0, 0, 0, "R9 all-ones squared");
    run_mul(one, one, 0, 0, 0, "R9 one times one");

    for (int i = 0; i < W; i++)
      run_mul(W'(1) << i, ones ^ (W'(1) << (i % 7)), 0, 0, 0, "R2 walking a");
    for (int i = 0; i < W; i++)
      run_mul(RED ^ (W'(3) << (W - 2)), W'(1) << i, 0, 0, 0, "R2 walking b");
    for (int i = 0; i < 40; i++) begin
      ra = {$urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom};
      run_mul(ra, rb, 0, 0, 0, "R2 random operands");
    end

    for (int i = 0; i < 6; i++) begin
      ra = {$urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom};
      run_mul(ra, rb, 0, 0, 3 + 3 * i, "R6 start while busy ignored");
      run_mul(ra, rb, 1 + 4 * i, 1 + i, 0, "R7 resume after clock-enable gap");
    end

    held = product;
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      op_a = {$urandom, $urandom, $urandom};
      op_b = {$urandom, $urandom, $urandom};
    end
    check(product === held && done === 1'b0 && busy === 1'b0, "R8 idle outputs unchanged",
          product, held);

    clk_en = 1'b0;
    start = 1'b1;
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && product === held, "R7 start ignored while gated", W'(busy), W'(0));
    start = 1'b0;
    clk_en = 1'b1;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule